// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a four-bank DRAM must be refreshed and asks a command arbiter to issue the needed commands. A free-running interval counter, reloaded from a programmable cycle count, produces one refresh obligation per period. Obligations collect in a debt counter. The arbiter may therefore defer refreshes while traffic is heavy and later grant them back to back. When the debt reaches its cap, the block flags the request as urgent.

Before a refresh, the scheduler makes sure every bank is closed. If any bank is open, it first asks for a precharge-all and waits the row precharge time. Granted refreshes are spaced by the refresh cycle time. A low-power request turns the pending work into a self-refresh entry, which drops the clock enable. When the request is withdrawn, the scheduler raises the clock enable again and holds two lockout flags low: one releases non-read commands, and a later one releases reads.

Top module: `refresh_sched`

## Requirements
- R1: The debt counter gains one per elapsed interval. With `intervalCycles` = N (N >= 2), consecutive increments are exactly N cycles apart when no refresh is granted.
- R2: In the cycle after the debt becomes non-zero with all banks idle, `cmdReq` rises with `cmdKind` = 2 (refresh). Each granted refresh lowers the debt by one. A tick and a grant in the same cycle leave the debt unchanged. A debt of 8 is fully drained by 8 grants.
- R3: The debt saturates at 8 (parameter `DEBT_MAX`). Further ticks leave it at 8.
- R4: `urgent` is high exactly while the debt equals 8.
- R5: Two refresh grants are at least `TRFC_CYC` cycles apart. With `grant` held high they are exactly `TRFC_CYC` cycles apart.
- R6: If a bank is open when work is due, the request first carries `cmdKind` = 1 (precharge-all). A refresh request is raised only after a cycle in which `allBanksIdle` was high.
- R7: A granted precharge-all is followed by a refresh request exactly `TRP_CYC` cycles after the grant cycle, with no request in between.
- R8: `lowPowerReq` raises a request with `cmdKind` = 3 (self-refresh entry), and this replaces a pending, ungranted refresh request. In the cycle after that grant, `cke` is low, the debt is 0, and `cmdReq` stays low for as long as `cke` is low.
- R9: While in self refresh, interval ticks are ignored and the debt stays 0.
- R10: Dropping `lowPowerReq` in self refresh raises `cke` in the next cycle. `nonReadOk` rises `TXSNR_CYC` cycles after `cke` rises. No request is raised before `nonReadOk` is high.
- R11: `readOk` rises `TXSRD_CYC` cycles after `cke` rises and is never high while `nonReadOk` is low.
- R12: During and right after reset, `cmdReq`, `urgent` and `debt` are 0, and `cke`, `nonReadOk` and `readOk` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| intervalCycles | input | IW | Refresh period in clock cycles (>= 2) |
| allBanksIdle | input | 1 | High when every bank is precharged |
| lowPowerReq | input | 1 | Request to enter and stay in self refresh |
| grant | input | 1 | Arbiter accepts the current request |
| cmdReq | output | 1 | A command is requested |
| cmdKind | output | 2 | 0 none, 1 precharge-all, 2 refresh, 3 self-refresh entry |
| urgent | output | 1 | Debt at its cap |
| debt | output | $clog2(DEBT_MAX+1) | Postponed refresh count |
| cke | output | 1 | Clock enable for the memory |
| nonReadOk | output | 1 | Non-read commands allowed after self-refresh exit |
| readOk | output | 1 | Read commands allowed after self-refresh exit |

## Verification
Every result is due a fixed number of cycles after its cause:
- The debt changes one cycle after an interval tick or a grant.
- A refresh request follows the first non-zero debt by one cycle.
- After a precharge-all grant, the refresh request comes `TRP_CYC` cycles later; after a refresh grant, the next refresh request comes `TRFC_CYC` cycles later.
- `cke` follows a self-refresh entry grant or exit by one cycle.
- The lockout flags rise `TXSNR_CYC + 1` and `TXSRD_CYC + 1` cycles after exit is requested.

The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the one where it changed a stimulus, and checks both the last cycle before each expected change and the cycle of the change itself.

// File: rtl/refresh_sched_pkg.sv
`timescale 1ns/1ps
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_PREALL  = 2'd1,
    CMD_REFRESH = 2'd2,
    CMD_SRENTER = 2'd3
  } cmdKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_REQ,
    ST_PRE_WAIT,
    ST_REF_REQ,
    ST_RFC_WAIT,
    ST_SR_REQ,
    ST_SELF,
    ST_XS_WAIT
  } schedState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tickEn;   // interval timer runs
    logic debtDec;  // refresh granted
    logic debtClr;  // self refresh entered
    logic loadRp;   // start precharge wait
    logic loadRfc;  // start refresh cycle wait
    logic xsClr;    // restart exit lockout timer
  } ctrlStrobe_t;

endpackage

// File: rtl/refresh_sched_dp.sv
`timescale 1ns/1ps
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int IW        = 16,
  parameter int DEBT_MAX  = 8,
  parameter int TRP_CYC   = 5,
  parameter int TRFC_CYC  = 18,
  parameter int TXSNR_CYC = 19,
  parameter int TXSRD_CYC = 200,
  localparam int DW       = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] intervalCycles,
  input  ctrlStrobe_t   strobe,
  output logic [DW-1:0] debt,
  output logic          waitDone,
  output logic          nonReadDone,
  output logic          readDone
);

  localparam int WAIT_MAX = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int WW       = $clog2(WAIT_MAX + 1);
  localparam int XW       = $clog2(TXSRD_CYC + 1);
  localparam logic [DW-1:0] DEBT_TOP = DW'(DEBT_MAX);
  localparam logic [WW-1:0] RP_LOAD  = WW'(TRP_CYC - 2);
  localparam logic [WW-1:0] RFC_LOAD = WW'(TRFC_CYC - 2);
  localparam logic [XW-1:0] XS_TOP   = XW'(TXSRD_CYC);
  localparam logic [XW-1:0] XS_NR    = XW'(TXSNR_CYC);

  logic [IW-1:0] intervalCnt;
  logic [WW-1:0] waitCnt;
  logic [XW-1:0] xsCnt;
  logic          tick;

  assign tick = strobe.tickEn && (intervalCnt >= (intervalCycles - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intervalCnt <= '0;
    else if (!strobe.tickEn) intervalCnt <= '0;
    else if (tick)           intervalCnt <= '0;
    else                     intervalCnt <= intervalCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debt <= '0;
    end else if (strobe.debtClr) begin
      debt <= '0;
    end else if (tick && !strobe.debtDec) begin
      if (debt != DEBT_TOP) debt <= debt + 1'b1;
    end else if (!tick && strobe.debtDec) begin
      if (debt != '0) debt <= debt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.loadRp)   waitCnt <= RP_LOAD;
    else if (strobe.loadRfc)  waitCnt <= RFC_LOAD;
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              xsCnt <= XS_TOP;
    else if (strobe.xsClr)  xsCnt <= '0;
    else if (xsCnt != XS_TOP) xsCnt <= xsCnt + 1'b1;
  end

  assign nonReadDone = (xsCnt >= XS_NR);
  assign readDone    = (xsCnt >= XS_TOP);

endmodule

// File: rtl/refresh_sched_ctrl.sv
`timescale 1ns/1ps
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grant,
  input  logic        allBanksIdle,
  input  logic        lowPowerReq,
  input  logic        debtNonZero,
  input  logic        waitDone,
  input  logic        nonReadDone,
  output ctrlStrobe_t strobe,
  output logic        cmdReq,
  output cmdKind_e    cmdKind,
  output logic        cke
);

  schedState_e state, stateNext;

  function automatic schedState_e pickWork(input logic lp, input logic owed,
                                           input logic idle);
    if (!(lp || owed)) return ST_IDLE;
    if (!idle)         return ST_PRE_REQ;
    if (lp)            return ST_SR_REQ;
    return ST_REF_REQ;
  endfunction

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     stateNext = pickWork(lowPowerReq, debtNonZero, allBanksIdle);
      ST_PRE_REQ:  if (grant) stateNext = ST_PRE_WAIT;
      ST_PRE_WAIT: if (waitDone)
                     stateNext = pickWork(lowPowerReq, debtNonZero, allBanksIdle);
      ST_REF_REQ:  if (grant)            stateNext = ST_RFC_WAIT;
                   else if (lowPowerReq) stateNext = ST_SR_REQ;
      ST_RFC_WAIT: if (waitDone)
                     stateNext = pickWork(lowPowerReq, debtNonZero, allBanksIdle);
      ST_SR_REQ:   if (grant) stateNext = ST_SELF;
      ST_SELF:     if (!lowPowerReq) stateNext = ST_XS_WAIT;
      ST_XS_WAIT:  if (nonReadDone)
                     stateNext = pickWork(lowPowerReq, debtNonZero, allBanksIdle);
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe         = '0;
    strobe.tickEn  = (state != ST_SELF);
    strobe.debtDec = (state == ST_REF_REQ) && grant;
    strobe.debtClr = (state == ST_SR_REQ) && grant;
    strobe.loadRp  = (state == ST_PRE_REQ) && grant;
    strobe.loadRfc = (state == ST_REF_REQ) && grant;
    strobe.xsClr   = (state == ST_SELF) || ((state == ST_SR_REQ) && grant);
  end

  always_comb begin
    unique case (state)
      ST_PRE_REQ: cmdKind = CMD_PREALL;
      ST_REF_REQ: cmdKind = CMD_REFRESH;
      ST_SR_REQ:  cmdKind = CMD_SRENTER;
      default:    cmdKind = CMD_NONE;
    endcase
  end

  assign cmdReq = (cmdKind != CMD_NONE);
  assign cke    = (state != ST_SELF);

endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int IW        = 16,
  parameter int DEBT_MAX  = 8,
  parameter int TRP_CYC   = 5,
  parameter int TRFC_CYC  = 18,
  parameter int TXSNR_CYC = 19,
  parameter int TXSRD_CYC = 200,
  localparam int DW       = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] intervalCycles,
  input  logic          allBanksIdle,
  input  logic          lowPowerReq,
  input  logic          grant,
  output logic          cmdReq,
  output logic [1:0]    cmdKind,
  output logic          urgent,
  output logic [DW-1:0] debt,
  output logic          cke,
  output logic          nonReadOk,
  output logic          readOk
);

  ctrlStrobe_t strobe;
  cmdKind_e    kindEnum;
  logic        waitDone;
  logic        nonReadDone;
  logic        readDone;

  refresh_sched_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .grant        (grant),
    .allBanksIdle (allBanksIdle),
    .lowPowerReq  (lowPowerReq),
    .debtNonZero  (debt != '0),
    .waitDone     (waitDone),
    .nonReadDone  (nonReadDone),
    .strobe       (strobe),
    .cmdReq       (cmdReq),
    .cmdKind      (kindEnum),
    .cke          (cke)
  );

  refresh_sched_dp #(
    .IW        (IW),
    .DEBT_MAX  (DEBT_MAX),
    .TRP_CYC   (TRP_CYC),
    .TRFC_CYC  (TRFC_CYC),
    .TXSNR_CYC (TXSNR_CYC),
    .TXSRD_CYC (TXSRD_CYC)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .intervalCycles (intervalCycles),
    .strobe         (strobe),
    .debt           (debt),
    .waitDone       (waitDone),
    .nonReadDone    (nonReadDone),
    .readDone       (readDone)
  );

  assign cmdKind   = kindEnum;
  assign urgent    = (debt == DW'(DEBT_MAX));
  assign nonReadOk = nonReadDone;
  assign readOk    = readDone;

endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
  parameter int IW        = 16,
  parameter int DEBT_MAX  = 8,
  parameter int TRFC_CYC  = 18,
  localparam int DW       = $clog2(DEBT_MAX + 1),
  localparam int SW       = $clog2(TRFC_CYC + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          allBanksIdle,
  input logic          grant,
  input logic          cmdReq,
  input logic [1:0]    cmdKind,
  input logic [DW-1:0] debt,
  input logic          cke,
  input logic          nonReadOk,
  input logic          readOk
);

  logic          refGrant;
  logic          refReq;
  logic [SW-1:0] sinceRef;

  assign refReq   = cmdReq && (cmdKind == 2'd2);
  assign refGrant = refReq && grant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       sinceRef <= SW'(TRFC_CYC);
    else if (refGrant)               sinceRef <= '0;
    else if (sinceRef != SW'(TRFC_CYC)) sinceRef <= sinceRef + 1'b1;
  end

  AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    int'(debt) <= DEBT_MAX);  // R3

  AST_DEBT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (debt != $past(debt)) |->
      ((int'(debt) - int'($past(debt)) == 1) ||
       (int'($past(debt)) - int'(debt) == 1) || (debt == '0)));  // R1

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    refGrant |-> (int'(sinceRef) >= TRFC_CYC - 1));  // R5

  AST_REF_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReq) |-> $past(allBanksIdle));  // R6

  AST_QUIET_IN_SELF: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> !cmdReq);  // R8

  AST_NO_DEBT_IN_SELF: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (debt == '0));  // R9

  AST_LOCKOUT_LOW_IN_SELF: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> !nonReadOk);  // R10

  AST_READ_AFTER_NONREAD: assert property (@(posedge clk) disable iff (!rstN)
    readOk |-> nonReadOk);  // R11

endmodule

bind refresh_sched refresh_sched_chk #(
  .IW       (IW),
  .DEBT_MAX (DEBT_MAX),
  .TRFC_CYC (TRFC_CYC)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .allBanksIdle (allBanksIdle),
  .grant        (grant),
  .cmdReq       (cmdReq),
  .cmdKind      (cmdKind),
  .debt         (debt),
  .cke          (cke),
  .nonReadOk    (nonReadOk),
  .readOk       (readOk)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;

  localparam int IW    = 16;
  localparam int TRP   = 5;
  localparam int TRFC  = 18;
  localparam int TXSNR = 19;
  localparam int TXSRD = 200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] intervalCycles = 16'd40;
  logic          allBanksIdle = 1'b1;
  logic          lowPowerReq = 1'b0;
  logic          grant = 1'b0;
  logic          cmdReq;
  logic [1:0]    cmdKind;
  logic          urgent;
  logic [3:0]    debt;
  logic          cke;
  logic          nonReadOk;
  logic          readOk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  refresh_sched #(
    .IW(IW), .DEBT_MAX(8), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD)
  ) uut (
    .clk(clk), .rstN(rstN), .intervalCycles(intervalCycles),
    .allBanksIdle(allBanksIdle), .lowPowerReq(lowPowerReq), .grant(grant),
    .cmdReq(cmdReq), .cmdKind(cmdKind), .urgent(urgent), .debt(debt),
    .cke(cke), .nonReadOk(nonReadOk), .readOk(readOk)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic t_reset();
    step(1);
    chkEq("R12 cmdReq", cmdReq, 0);
    chkEq("R12 debt", debt, 0);
    chkEq("R12 urgent", urgent, 0);
    chkEq("R12 cke", cke, 1);
    chkEq("R12 nonReadOk", nonReadOk, 1);
    chkEq("R12 readOk", readOk, 1);
    step(4);
    rstN = 1'b1;
    step(1);
    chkEq("R12 debt after release", debt, 0);
    chkEq("R12 cmdReq after release", cmdReq, 0);
  endtask

  task automatic t_interval();
    int t1;
    int lim;
    lim = 0;
    while (debt != 4'd1 && lim < 200) begin step(1); lim++; end
    chkEq("R2 no request same cycle", cmdReq, 0);
    t1 = cyc;
    step(1);
    chkEq("R2 request rises", cmdReq, 1);
    chkEq("R2 kind refresh", cmdKind, 2);
    lim = 0;
    while (debt != 4'd2 && lim < 200) begin step(1); lim++; end
    chkEq("R1 interval spacing", cyc - t1, 40);
  endtask

  task automatic t_cap();
    int lim;
    lim = 0;
    while (debt != 4'd7 && lim < 400) begin step(1); lim++; end
    chkEq("R4 not urgent at 7", urgent, 0);
    lim = 0;
    while (debt != 4'd8 && lim < 100) begin step(1); lim++; end
    chkEq("R4 urgent at 8", urgent, 1);
    step(120);
    chkEq("R3 debt saturated", debt, 8);
    chkEq("R4 urgent held", urgent, 1);
  endtask

  task automatic t_burst();
    int last;
    int nRef;
    int lim;
    intervalCycles = 16'd1000;
    grant = 1'b1;
    last = -1;
    nRef = 0;
    lim = 0;
    while (!(debt == 4'd0 && !cmdReq) && lim < 400) begin
      if (cmdReq && cmdKind == 2'd2) begin
        if (last >= 0) chkEq("R5 back-to-back spacing", cyc - last, TRFC);
        last = cyc;
        nRef++;
      end
      step(1);
      lim++;
    end
    grant = 1'b0;
    chkEq("R2 refreshes to drain", nRef, 8);
    step(TRFC + 2);
    chkEq("R2 idle after drain", cmdReq, 0);
    chkEq("R2 debt drained", debt, 0);
  endtask

  task automatic t_precharge();
    int lim;
    allBanksIdle = 1'b0;
    intervalCycles = 16'd30;
    lim = 0;
    while (!cmdReq && lim < 100) begin step(1); lim++; end
    chkEq("R6 precharge first", cmdKind, 1);
    intervalCycles = 16'd1000;
    grant = 1'b1;
    step(1);
    grant = 1'b0;
    allBanksIdle = 1'b1;
    step(TRP - 2);
    chkEq("R7 quiet during precharge wait", cmdReq, 0);
    step(1);
    chkEq("R7 refresh after precharge", cmdKind, 2);
    chkEq("R7 request after precharge", cmdReq, 1);
    grant = 1'b1;
    step(1);
    grant = 1'b0;
    step(TRFC + 2);
    chkEq("R2 debt back to zero", debt, 0);
  endtask

  task automatic t_selfref();
    int lim;
    intervalCycles = 16'd5;
    lim = 0;
    while (debt < 4'd2 && lim < 50) begin step(1); lim++; end
    chkEq("R2 pending refresh", cmdKind, 2);
    lowPowerReq = 1'b1;
    step(1);
    chkEq("R8 entry replaces refresh", cmdKind, 3);
    grant = 1'b1;
    step(1);
    grant = 1'b0;
    chkEq("R8 cke low", cke, 0);
    chkEq("R8 debt cleared", debt, 0);
    chkEq("R8 no request in self refresh", cmdReq, 0);
    chkEq("R10 nonReadOk low in self refresh", nonReadOk, 0);
    chkEq("R11 readOk low in self refresh", readOk, 0);
    step(300);
    chkEq("R9 ticks ignored", debt, 0);
    chkEq("R9 cke still low", cke, 0);
    lowPowerReq = 1'b0;
    for (int k = 1; k <= TXSRD + 1; k++) begin
      step(1);
      if (k == 1) chkEq("R10 cke rises", cke, 1);
      if (k == TXSNR) chkEq("R10 nonReadOk before", nonReadOk, 0);
      if (k == TXSNR + 1) begin
        chkEq("R10 nonReadOk at", nonReadOk, 1);
        chkEq("R10 no request in lockout", cmdReq, 0);
      end
      if (k == TXSNR + 2) chkEq("R10 refresh after lockout", cmdKind, 2);
      if (k == TXSRD) chkEq("R11 readOk before", readOk, 0);
      if (k == TXSRD + 1) chkEq("R11 readOk at", readOk, 1);
    end
  endtask

  initial begin
    t_reset();
    t_interval();
    t_cap();
    t_burst();
    t_precharge();
    t_selfref();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule